// File: doc/BRIEF.md
# Two-Phase Microinstruction Controller

This block runs a small 16-bit register-file datapath. Each instruction takes two clocks. In the first clock (fetch) the controller runs a fixed built-in word. That word reads memory at the program counter (register 7), stores the returned word as the next instruction, and writes the program counter back incremented through the ALU. In the second clock (execute) the stored instruction is decoded into the following controls:

- memory strobes
- two register selects
- a flag-update enable
- a carry source
- an ALU mode and function

The result is written to the register named by the A-port select.

For logic operations the carry input is meaningless, so the two carry-select bits take on a second job: they gate the write-back on the stored flags. A register move into register 7 that depends on a flag therefore acts as a conditional jump. The same bits can also block the write-back completely, which gives a compare that changes only the flags. The block holds the eight-entry register file, the ALU and the two flag registers. Memory and address decoding sit outside it.

Top module: `ucp_core`

## Requirements
- R1: A synchronous active-high reset puts the block in the fetch phase, clears every register (including the program counter, register 7) and clears both flags.
- R2: Fetch and execute alternate strictly, one clock each. `exec_phase` is 0 in fetch and 1 in execute.
- R3: In fetch the decoded word is 0xBF80. This means memory read = 1, memory write = 0, A select = 7, flag update off, carry select 00, arithmetic mode, function 0. `mem_addr` shows register 7.
- R4: At the end of fetch, `mem_rdata` is stored as the next instruction and register 7 is incremented. No other register changes.
- R5: Instruction fields are as follows:
  - bit 15: memory read.
  - bit 14: memory write.
  - bits 13:11: A select.
  - bits 10:8: B select.
  - bit 7: flag update, active low.
  - bits 6:5: carry select.
  - bit 4: mode (1 = logic, 0 = arithmetic).
  - bits 3:0: function.

  In execute these fields drive the matching outputs.
- R6: In arithmetic mode the carry input is 1, CY, EQ or 0 for select 00, 01, 10 or 11. Write-back is always enabled.
- R7: In logic mode the write-back depends on the select: 00 always writes, 01 writes only if CY = 1, 10 writes only if EQ = 1, and 11 never writes. `reg_wr_en` reflects this decision. The decision uses the flag values held before this execute clock.
- R8: Write-back goes to the A-selected register. Writing register 7 changes the next fetch address (a jump). A blocked write leaves the next fetch at the incremented address.
- R9: The flags change only at the end of an execute clock whose bit 7 is 0. EQ becomes (A == B). CY becomes the carry out of the arithmetic sum, and is 0 in logic mode.
- R10: `mem_addr` carries the A-port value and `mem_wdata` carries the B-port value. `mem_wr` is asserted only in execute. An execute memory read loads `mem_rdata` into the B-selected register. When both ports name the same register, the ALU write-back takes priority.
- R11: Arithmetic functions:
  - 0: A + cin.
  - 1: A + B + cin.
  - 2: A + ~B + cin.
  - 3: A + all-ones + cin.

  Logic functions:
  - 0: A.
  - 1: B.
  - 2: A AND B.
  - 3: A OR B.
  - 4: A XOR B.
  - 5: NOT A.
  - 6: NOT B.
  - 7: zero.

  Any other function code behaves like function 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_rdata | input | DATA_W | Word returned by memory (instruction in fetch, data in execute) |
| mem_addr | output | DATA_W | A-port register value, used as the memory address |
| mem_wdata | output | DATA_W | B-port register value, used as write data |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe (execute only) |
| exec_phase | output | 1 | 0 in fetch, 1 in execute |
| a_sel | output | 3 | Decoded A-port register select |
| b_sel | output | 3 | Decoded B-port register select |
| flag_latch_en | output | 1 | Flags update at the end of this clock |
| cin_sel | output | 2 | Decoded carry / condition select |
| logic_mode | output | 1 | 1 when the ALU is in logic mode |
| alu_fn | output | 4 | Decoded ALU function |
| reg_wr_en | output | 1 | A-port write-back enable after condition gating |
| alu_y | output | DATA_W | ALU result |
| flag_eq | output | 1 | Stored EQ flag |
| flag_cy | output | 1 | Stored CY flag |

## Verification
The bench builds the block with its defaults: a 16-bit datapath, eight registers and register 7 as the program counter. At that width a handful of instructions is enough to add 0xFFFF to itself and produce a carry, and every select value can reach a real register. All four conditions of the logic-mode gating are driven while the flags hold opposite values, so taken jumps, fall-through and the compare-only form can all be observed through later fetch addresses. A reset in the middle of execute, followed by reads of each register, confirms that the whole file and both flags are cleared.

// File: rtl/ucp_pkg.sv
package ucp_pkg;

    localparam int INSTR_W = 16;
    localparam logic [INSTR_W-1:0] FETCH_WORD = 16'hBF80;

    typedef enum logic {
        PH_FETCH = 1'b0,
        PH_EXEC  = 1'b1
    } phase_e;

    typedef enum logic [1:0] {
        CS_ONE  = 2'b00,
        CS_CY   = 2'b01,
        CS_EQ   = 2'b10,
        CS_ZERO = 2'b11
    } csel_e;

    // Field order is the bit order of the instruction word, MSB first.
    typedef struct packed {
        logic       rd;
        logic       wr;
        logic [2:0] a_sel;
        logic [2:0] b_sel;
        logic       latch_n;
        csel_e      csel;
        logic       logic_op;
        logic [3:0] fn;
    } uword_t;

    // Arithmetic function codes
    localparam logic [3:0] AR_A_CIN = 4'd0;
    localparam logic [3:0] AR_A_B   = 4'd1;
    localparam logic [3:0] AR_A_NB  = 4'd2;
    localparam logic [3:0] AR_A_M1  = 4'd3;

    // Logic function codes
    localparam logic [3:0] LG_A    = 4'd0;
    localparam logic [3:0] LG_B    = 4'd1;
    localparam logic [3:0] LG_AND  = 4'd2;
    localparam logic [3:0] LG_OR   = 4'd3;
    localparam logic [3:0] LG_XOR  = 4'd4;
    localparam logic [3:0] LG_NA   = 4'd5;
    localparam logic [3:0] LG_NB   = 4'd6;
    localparam logic [3:0] LG_ZERO = 4'd7;

    // One selector serves both the carry input and the write-back condition.
    function automatic logic csel_pick(input csel_e s, input logic cy, input logic eq);
        logic r;
        case (s)
            CS_ONE:  r = 1'b1;
            CS_CY:   r = cy;
            CS_EQ:   r = eq;
            default: r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/ucp_phase.sv
module ucp_phase
    import ucp_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [INSTR_W-1:0] fetch_word_in,
    output phase_e             phase,
    output logic [INSTR_W-1:0] ir
);

    phase_e             phase_q;
    logic [INSTR_W-1:0] ir_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_FETCH;
            ir_q    <= '0;
        end else begin
            phase_q <= (phase_q == PH_FETCH) ? PH_EXEC : PH_FETCH;
            if (phase_q == PH_FETCH) begin
                ir_q <= fetch_word_in;
            end
        end
    end

    assign phase = phase_q;
    assign ir    = ir_q;

    p_fetch_then_exec_r2: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_FETCH) |=> (phase_q == PH_EXEC));

    p_exec_then_fetch_r2: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_EXEC) |=> (phase_q == PH_FETCH));

    p_ir_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_EXEC) |=> (ir_q == $past(ir_q)));

endmodule

// File: rtl/ucp_decode.sv
module ucp_decode
    import ucp_pkg::*;
(
    input  phase_e             phase,
    input  logic [INSTR_W-1:0] ir,
    input  logic               flag_cy,
    input  logic               flag_eq,
    output uword_t             word,
    output logic               a_we,
    output logic               b_we,
    output logic               latch_en,
    output logic               cin
);

    logic cond;

    always_comb begin
        word     = (phase == PH_FETCH) ? uword_t'(FETCH_WORD) : uword_t'(ir);
        cond     = csel_pick(word.csel, flag_cy, flag_eq);
        // Logic ops ignore the carry; the select gates write-back instead.
        cin      = word.logic_op ? 1'b0 : cond;
        a_we     = word.logic_op ? cond : 1'b1;
        b_we     = (phase == PH_EXEC) && word.rd;
        latch_en = (phase == PH_EXEC) && !word.latch_n;
    end

endmodule

// File: rtl/ucp_alu.sv
module ucp_alu
    import ucp_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              cin,
    input  logic              logic_op,
    input  logic [3:0]        fn,
    output logic [DATA_W-1:0] y,
    output logic              cy,
    output logic              eq
);

    localparam int SUM_W = DATA_W + 1;

    logic [DATA_W-1:0] addend;
    logic [SUM_W-1:0]  sum;
    logic [DATA_W-1:0] lres;

    always_comb begin
        case (fn)
            AR_A_B:  addend = b;
            AR_A_NB: addend = ~b;
            AR_A_M1: addend = '1;
            default: addend = '0;
        endcase
        sum = SUM_W'(a) + SUM_W'(addend) + SUM_W'(cin);

        case (fn)
            LG_A:    lres = a;
            LG_B:    lres = b;
            LG_AND:  lres = a & b;
            LG_OR:   lres = a | b;
            LG_XOR:  lres = a ^ b;
            LG_NA:   lres = ~a;
            LG_NB:   lres = ~b;
            LG_ZERO: lres = '0;
            default: lres = a;
        endcase

        y  = logic_op ? lres : sum[DATA_W-1:0];
        cy = logic_op ? 1'b0 : sum[DATA_W];
        eq = (a == b);
    end

    always_comb begin
        if (logic_op) begin
            p_logic_no_carry_r9: assert (!cy);
        end
    end

endmodule

// File: rtl/ucp_regfile.sv
module ucp_regfile #(
    parameter int DATA_W  = 16,
    parameter int REG_CNT = 8,
    parameter int PC_IDX  = 7,
    localparam int SEL_W  = $clog2(REG_CNT)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SEL_W-1:0]  ra,
    input  logic [SEL_W-1:0]  rb,
    output logic [DATA_W-1:0] qa,
    output logic [DATA_W-1:0] qb,
    input  logic              we_a,
    input  logic [DATA_W-1:0] da,
    input  logic              we_b,
    input  logic [DATA_W-1:0] db
);

    logic [REG_CNT-1:0][DATA_W-1:0] file_w;

    for (genvar g = 0; g < REG_CNT; g++) begin : g_reg
        logic [DATA_W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (we_a && (ra == SEL_W'(g))) begin
                q <= da;                // A-port write-back wins
            end else if (we_b && (rb == SEL_W'(g))) begin
                q <= db;
            end
        end
        assign file_w[g] = q;
    end

    assign qa = file_w[ra];
    assign qb = file_w[rb];

    p_pc_cleared_r1: assert property (@(posedge clk)
        $past(rst) |-> (file_w[PC_IDX] == '0));

    p_port_priority_r10: assert property (@(posedge clk) disable iff (rst)
        (we_a && we_b && (ra == rb)) |=> (file_w[$past(ra)] == $past(da)));

endmodule

// File: rtl/ucp_core.sv
module ucp_core
    import ucp_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int REG_CNT = 8,
    parameter int PC_IDX  = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              exec_phase,
    output logic [2:0]        a_sel,
    output logic [2:0]        b_sel,
    output logic              flag_latch_en,
    output logic [1:0]        cin_sel,
    output logic              logic_mode,
    output logic [3:0]        alu_fn,
    output logic              reg_wr_en,
    output logic [DATA_W-1:0] alu_y,
    output logic              flag_eq,
    output logic              flag_cy
);

    localparam int SEL_W = $clog2(REG_CNT);

    phase_e             phase;
    logic [INSTR_W-1:0] ir;
    uword_t             word;
    logic               a_we, b_we, latch_en, cin;
    logic [DATA_W-1:0]  a_bus, b_bus, y;
    logic               alu_cy, alu_eq;
    logic               eq_q, cy_q;

    ucp_phase u_phase (
        .clk           (clk),
        .rst           (rst),
        .fetch_word_in (mem_rdata[INSTR_W-1:0]),
        .phase         (phase),
        .ir            (ir)
    );

    ucp_decode u_decode (
        .phase    (phase),
        .ir       (ir),
        .flag_cy  (cy_q),
        .flag_eq  (eq_q),
        .word     (word),
        .a_we     (a_we),
        .b_we     (b_we),
        .latch_en (latch_en),
        .cin      (cin)
    );

    ucp_regfile #(
        .DATA_W  (DATA_W),
        .REG_CNT (REG_CNT),
        .PC_IDX  (PC_IDX)
    ) u_regs (
        .clk  (clk),
        .rst  (rst),
        .ra   (SEL_W'(word.a_sel)),
        .rb   (SEL_W'(word.b_sel)),
        .qa   (a_bus),
        .qb   (b_bus),
        .we_a (a_we),
        .da   (y),
        .we_b (b_we),
        .db   (mem_rdata)
    );

    ucp_alu #(
        .DATA_W (DATA_W)
    ) u_alu (
        .a        (a_bus),
        .b        (b_bus),
        .cin      (cin),
        .logic_op (word.logic_op),
        .fn       (word.fn),
        .y        (y),
        .cy       (alu_cy),
        .eq       (alu_eq)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            eq_q <= 1'b0;
            cy_q <= 1'b0;
        end else if (latch_en) begin
            eq_q <= alu_eq;
            cy_q <= alu_cy;
        end
    end

    assign mem_addr      = a_bus;
    assign mem_wdata     = b_bus;
    assign mem_rd        = word.rd;
    assign mem_wr        = (phase == PH_EXEC) && word.wr;
    assign exec_phase    = (phase == PH_EXEC);
    assign a_sel         = word.a_sel;
    assign b_sel         = word.b_sel;
    assign flag_latch_en = latch_en;
    assign cin_sel       = word.csel;
    assign logic_mode    = word.logic_op;
    assign alu_fn        = word.fn;
    assign reg_wr_en     = a_we;
    assign alu_y         = y;
    assign flag_eq       = eq_q;
    assign flag_cy       = cy_q;

    p_fetch_word_r3: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_FETCH) |-> (word == uword_t'(FETCH_WORD)));

    p_ir_capture_r4: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_FETCH) |=> (ir == $past(mem_rdata[INSTR_W-1:0])));

    p_never_write_r7: assert property (@(posedge clk) disable iff (rst)
        ((phase == PH_EXEC) && word.logic_op && (word.csel == CS_ZERO)) |-> !reg_wr_en);

    p_flag_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !latch_en |=> ((eq_q == $past(eq_q)) && (cy_q == $past(cy_q))));

    p_no_write_in_fetch_r10: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_FETCH) |-> !mem_wr);

endmodule

// File: tb/ucp_core_tb_top.sv
`timescale 1ns/1ps
module ucp_core_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] mem_rdata = '0;
    logic [15:0] mem_addr, mem_wdata, alu_y;
    logic        mem_rd, mem_wr, exec_phase, flag_latch_en, logic_mode, reg_wr_en, flag_eq, flag_cy;
    logic [2:0]  a_sel, b_sel;
    logic [1:0]  cin_sel;
    logic [3:0]  alu_fn;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [15:0] m_r [8];
    logic        m_eq, m_cy;

    always #2.5 clk = ~clk;

    ucp_core dut_i (
        .clk(clk), .rst(rst), .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .exec_phase(exec_phase), .a_sel(a_sel), .b_sel(b_sel),
        .flag_latch_en(flag_latch_en), .cin_sel(cin_sel), .logic_mode(logic_mode), .alu_fn(alu_fn),
        .reg_wr_en(reg_wr_en), .alu_y(alu_y), .flag_eq(flag_eq), .flag_cy(flag_cy)
    );

    function automatic logic [15:0] mk(input logic rd, input logic wr, input int a, input int b,
                                       input logic ln, input int cs, input logic lg, input int fn);
        return {rd, wr, 3'(a), 3'(b), ln, 2'(cs), lg, 4'(fn)};
    endfunction

    // {instruction, data presented during execute}
    localparam int NV = 20;
    localparam logic [31:0] VEC [NV] = '{
        {mk(1,0,0,1,1,3,1,0), 16'h1234},  // load R1, no write-back
        {mk(1,0,0,2,1,3,1,0), 16'h1234},  // load R2
        {mk(1,0,0,3,1,3,1,0), 16'h0040},  // load R3 (jump target)
        {mk(0,0,1,2,0,3,1,4), 16'h0000},  // compare R1,R2: flags only
        {mk(0,0,7,3,1,2,1,1), 16'h0000},  // R7 <= R3 if EQ (taken)
        {mk(0,0,7,1,1,1,1,1), 16'h0000},  // R7 <= R1 if CY (not taken)
        {mk(0,0,1,2,0,0,0,1), 16'h0000},  // R1 = R1+R2+1
        {mk(1,0,0,4,1,3,1,0), 16'hFFFF},  // load R4
        {mk(0,0,4,4,0,3,0,1), 16'h0000},  // R4 = R4+R4+0, carry out
        {mk(0,0,7,3,1,1,1,1), 16'h0000},  // R7 <= R3 if CY (taken)
        {mk(0,0,5,0,1,2,0,0), 16'h0000},  // R5 = R5 + EQ
        {mk(0,0,6,0,0,1,0,0), 16'h0000},  // R6 = R6 + CY, flags
        {mk(0,0,1,4,1,0,1,2), 16'h0000},  // R1 &= R4
        {mk(0,0,2,0,1,0,1,5), 16'h0000},  // R2 = ~R2
        {mk(0,0,1,1,0,0,0,2), 16'h0000},  // R1 = R1 - R1
        {mk(0,1,3,1,1,3,1,3), 16'h0000},  // memory write, no write-back
        {mk(1,0,2,2,1,0,0,0), 16'h5555},  // same index: ALU wins
        {mk(0,0,4,0,0,3,0,3), 16'h0000},  // R4 = R4 - 1
        {mk(0,0,6,3,1,0,1,6), 16'h0000},  // R6 = ~R3
        {mk(0,0,5,6,1,0,1,7), 16'h0000}   // R5 = 0
    };

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [16:0] ref_alu(input logic [15:0] a, input logic [15:0] b,
                                            input logic lg, input logic [3:0] fn, input logic ci);
        logic [16:0] r;
        if (lg) begin
            case (fn)
                4'd1: r = {1'b0, b};
                4'd2: r = {1'b0, a & b};
                4'd3: r = {1'b0, a | b};
                4'd4: r = {1'b0, a ^ b};
                4'd5: r = {1'b0, ~a};
                4'd6: r = {1'b0, ~b};
                4'd7: r = 17'd0;
                default: r = {1'b0, a};
            endcase
        end else begin
            case (fn)
                4'd1: r = {1'b0, a} + {1'b0, b} + 17'(ci);
                4'd2: r = {1'b0, a} + {1'b0, ~b} + 17'(ci);
                4'd3: r = {1'b0, a} + 17'h0FFFF + 17'(ci);
                default: r = {1'b0, a} + 17'(ci);
            endcase
        end
        return r;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 8; i++) m_r[i] = '0;
        m_eq = 1'b0;
        m_cy = 1'b0;
    endtask

    // Entered at a falling edge in the fetch phase; leaves at the next one.
    task automatic run_instr(input logic [15:0] w, input logic [15:0] d);
        int          a, b;
        logic        cond, ci, we;
        logic [15:0] av, bv;
        logic [16:0] res;
        chk("R2", "phase in fetch", exec_phase, 0);
        chk("R3 R8", "fetch address", mem_addr, m_r[7]);
        chk("R3", "fetch read", mem_rd, 1);
        chk("R3", "fetch write", mem_wr, 0);
        chk("R3", "fetch latch", flag_latch_en, 0);
        chk("R3", "fetch select", {a_sel, cin_sel, logic_mode, alu_fn}, {3'd7, 2'd0, 1'b0, 4'd0});
        chk("R9", "flag eq", flag_eq, m_eq);
        chk("R9", "flag cy", flag_cy, m_cy);
        mem_rdata = w;
        @(negedge clk);
        m_r[7] = m_r[7] + 16'd1;                       // R4
        a = int'(w[13:11]);
        b = int'(w[10:8]);
        chk("R2", "phase in execute", exec_phase, 1);
        chk("R4 R5", "decoded fields",
            {mem_rd, mem_wr, a_sel, b_sel, flag_latch_en, cin_sel, logic_mode, alu_fn},
            {w[15], w[14], w[13:11], w[10:8], ~w[7], w[6:5], w[4], w[3:0]});
        cond = (w[6:5] == 2'd0) ? 1'b1 : (w[6:5] == 2'd1) ? m_cy : (w[6:5] == 2'd2) ? m_eq : 1'b0;
        ci   = w[4] ? 1'b0 : cond;
        we   = w[4] ? cond : 1'b1;
        av   = m_r[a];
        bv   = m_r[b];
        res  = ref_alu(av, bv, w[4], w[3:0], ci);
        chk("R10", "A bus", mem_addr, av);
        chk("R10", "B bus", mem_wdata, bv);
        chk("R6 R11", "alu result", alu_y, res[15:0]);
        chk("R6 R7", "write enable", reg_wr_en, we);
        mem_rdata = d;
        if (w[15]) m_r[b] = d;
        if (we) m_r[a] = res[15:0];
        if (!w[7]) begin
            m_eq = (av == bv);
            m_cy = res[16];
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk("R1", "phase after reset", exec_phase, 0);
        chk("R1", "pc after reset", mem_addr, 16'h0000);
        chk("R1", "flags after reset", {flag_eq, flag_cy}, 2'b00);

        for (int i = 0; i < NV; i++) begin
            run_instr(VEC[i][31:16], VEC[i][15:0]);
        end

        // R7: blocked write leaves the next fetch at the incremented address
        run_instr(mk(0,0,7,1,1,3,1,1), 16'h0000);
        chk("R7 R8", "fall-through address", mem_addr, m_r[7]);

        // R1: reset in the middle of execute clears everything
        mem_rdata = mk(0,0,1,2,1,0,1,3);
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        model_reset();
        chk("R1", "phase after mid reset", exec_phase, 0);
        chk("R1", "pc after mid reset", mem_addr, 16'h0000);
        chk("R1", "flags after mid reset", {flag_eq, flag_cy}, 2'b00);
        for (int r = 0; r < 7; r++) begin
            run_instr(mk(0,0,r,r,1,3,1,0), 16'h0000);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule